// File: doc/BRIEF.md
# Iterative XTEA Cipher Engine

This block encrypts or decrypts one 64-bit block with the XTEA cipher. The block is held as two 32-bit halves, and the key is 128 bits held as four 32-bit words. The caller first loads the key words through a small write port. It then presents both halves, the direction and a cycle count, and pulses `start`. The engine runs iteratively and updates exactly one half on each clock. It raises `done` for one clock when the last half has been written. The result then stays on the output halves until the next accepted start.

The running round sum is kept inside the engine. The sum moves by the constant 0x9E3779B9 between the two half-updates of a cycle. One half picks its key word with sum bits [1:0], and the other half picks its key word with sum bits [12:11]. The key words can also be read back through a registered read port.

Top module: `xtea_engine`

## Requirements
- R1: A synchronous active-high reset clears both output halves, the internal sum, all four key words and the key read data to zero, and drops `busy` and `done`.
- R2: When `key_we` is high at a clock edge, the key word at `key_addr` (0..3) takes `key_wdata`. `key_rdata` shows the word selected by `key_addr` one clock later. A read and a write to the same word at the same edge return the old value.
- R3: With `decrypt`=0 the sum starts at zero. Each cycle first adds to v0 the value f(v1) XOR (sum + key[sum[1:0]]), where f(x) = ((x<<4) XOR (x>>5)) + x with logical shifts. The sum then grows by 0x9E3779B9. v1 then gains f(v0) XOR (sum + key[sum[12:11]]), using the new v0. All arithmetic wraps modulo 2^32.
- R4: With `decrypt`=1 the sum starts at 0x9E3779B9 times the cycle count, truncated to 32 bits. Each cycle first subtracts f(v0) XOR (sum + key[sum[12:11]]) from v1. The sum then drops by 0x9E3779B9. v0 then loses f(v1) XOR (sum + key[sum[1:0]]). Decrypting an encrypted block with the same key and count returns the original block.
- R5: For a count N>0, `busy` is high from the edge that takes `start` until the result is complete. `done` is high for exactly one clock, starting 2N edges after the edge that takes `start`, and `busy` is low while `done` is high.
- R6: A `start` pulse that arrives while `busy` is high is ignored. Neither the result nor the finishing time changes.
- R7: While idle and with no start, both output halves keep their values.
- R8: A count of zero returns the input halves unchanged on the outputs, pulses `done` on the clock after `start`, and never raises `busy`.
- R9: While busy, each clock changes at most one of the two halves. The halves are visible on the outputs in every cycle of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt; sampled with start |
| v0_in | input | 32 | First data half |
| v1_in | input | 32 | Second data half |
| cycles | input | CNT_W | Number of cipher cycles |
| key_we | input | 1 | Key word write enable |
| key_addr | input | 2 | Key word index for write and read |
| key_wdata | input | 32 | Key word write data |
| key_rdata | output | 32 | Registered key word read data |
| v0_out | output | 32 | First result half (working register) |
| v1_out | output | 32 | Second result half (working register) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
A start is taken at edge 0. The first half changes after edge 1. `done` and the final halves appear after edge 2N, and `busy` falls at the same edge. With a zero count, `done` and the copied inputs appear after edge 0. A key read shows its data after the edge that follows the address. A behavioural model in the bench advances at each rising edge with the same timing. Every output is compared with the model at the following falling edge, so every intermediate half is checked, not only the final ones. Closed-form encipher and decipher loops then confirm the final results, and a latency counter confirms the 2N+1 falling-edge distance from the start drive to `done`.

// File: rtl/xtea_pkg.sv
package xtea_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_AW = 2;
  localparam logic [WORD_W-1:0] XTEA_DELTA = 32'h9E37_79B9;

  // Shift-xor-add diffusion applied to one half.
  function automatic logic [WORD_W-1:0] xtea_mix(input logic [WORD_W-1:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;
endpackage

// File: rtl/xtea_key_store.sv
module xtea_key_store
  import xtea_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = KEY_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] lk_idx,
  output logic [W-1:0]  lk_word
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (we && addr == AW'(g))
        words[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= words[addr];
  end

  assign lk_word = words[lk_idx];

  AST_KEY_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> words[$past(addr)] == $past(wdata)) else $error("key write lost"); // R2
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(words[0]) && $stable(words[3])) else $error("key changed"); // R2
endmodule

// File: rtl/xtea_round_unit.sv
module xtea_round_unit
  import xtea_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = KEY_AW
) (
  input  logic [W-1:0]  v0,
  input  logic [W-1:0]  v1,
  input  logic [W-1:0]  sum,
  input  logic          dec,
  input  phase_e        phase,
  input  logic [W-1:0]  key_word,
  output logic [AW-1:0] key_idx,
  output logic          upd_v0,
  output logic [W-1:0]  new_half
);
  logic [W-1:0] src, dst, f;

  always_comb begin
    // Encrypt touches v0 first; decrypt touches v1 first.
    upd_v0  = dec ? (phase == PH_SECOND) : (phase == PH_FIRST);
    src     = upd_v0 ? v1 : v0;
    dst     = upd_v0 ? v0 : v1;
    key_idx = upd_v0 ? sum[1:0] : sum[12:11];
    f       = xtea_mix(src) ^ (sum + key_word);
    new_half = dec ? (dst - f) : (dst + f);
  end
endmodule

// File: rtl/xtea_ctrl.sv
module xtea_ctrl
  import xtea_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             decrypt,
  input  logic [CNT_W-1:0] cycles,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic             done,
  output logic             dec_q,
  output phase_e           phase
);
  localparam int STEP_W = CNT_W + 1;

  logic [STEP_W-1:0] left_q;

  assign load = start && !busy;
  assign step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      dec_q  <= 1'b0;
      phase  <= PH_FIRST;
      left_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        phase  <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
        left_q <= left_q - 1'b1;
        if (left_q == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        dec_q  <= decrypt;
        phase  <= PH_FIRST;
        left_q <= {cycles, 1'b0};
        if (cycles == '0) done <= 1'b1;
        else              busy <= 1'b1;
      end
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(dec_q)) else $error("start taken while busy"); // R6
  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cycles == '0) |=> done && !busy) else $error("zero count"); // R8
  AST_RUN_CONT: assert property (@(posedge clk) disable iff (rst)
    (busy && left_q > STEP_W'(1)) |=> busy && !done) else $error("run cut short"); // R5
endmodule

// File: rtl/xtea_engine.sv
module xtea_engine
  import xtea_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              decrypt,
  input  logic [31:0]       v0_in,
  input  logic [31:0]       v1_in,
  input  logic [CNT_W-1:0]  cycles,
  input  logic              key_we,
  input  logic [1:0]        key_addr,
  input  logic [31:0]       key_wdata,
  output logic [31:0]       key_rdata,
  output logic [31:0]       v0_out,
  output logic [31:0]       v1_out,
  output logic              busy,
  output logic              done
);
  logic              load, step, dec_q, upd_v0;
  phase_e            phase;
  logic [WORD_W-1:0] v0_q, v1_q, sum_q, key_word, new_half, dec_sum;
  logic [KEY_AW-1:0] key_idx;

  assign dec_sum = XTEA_DELTA * WORD_W'(cycles);

  xtea_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .cycles(cycles),
    .load(load), .step(step), .busy(busy), .done(done), .dec_q(dec_q), .phase(phase)
  );

  xtea_key_store #(.W(WORD_W), .AW(KEY_AW)) u_keys (
    .clk(clk), .rst(rst), .we(key_we), .addr(key_addr), .wdata(key_wdata),
    .rdata(key_rdata), .lk_idx(key_idx), .lk_word(key_word)
  );

  xtea_round_unit #(.W(WORD_W), .AW(KEY_AW)) u_round (
    .v0(v0_q), .v1(v1_q), .sum(sum_q), .dec(dec_q), .phase(phase),
    .key_word(key_word), .key_idx(key_idx), .upd_v0(upd_v0), .new_half(new_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q  <= '0;
      v1_q  <= '0;
      sum_q <= '0;
    end else if (load) begin
      v0_q  <= v0_in;
      v1_q  <= v1_in;
      sum_q <= decrypt ? dec_sum : '0;
    end else if (step) begin
      if (upd_v0) v0_q <= new_half;
      else        v1_q <= new_half;
      if (phase == PH_FIRST)
        sum_q <= dec_q ? (sum_q - XTEA_DELTA) : (sum_q + XTEA_DELTA);
    end
  end

  assign v0_out = v0_q;
  assign v1_out = v1_q;

  AST_ONE_HALF: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(v0_q) || $stable(v1_q))) else $error("both halves moved"); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(v0_q) && $stable(v1_q)) else $error("idle drift"); // R7
  AST_ENC_SUM0: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !decrypt) |=> sum_q == '0) else $error("enc sum start"); // R3
endmodule

// File: tb/xtea_engine_bench.sv
module xtea_engine_bench;
  localparam int CNT_W = 8;
  localparam logic [31:0] DLT = 32'h9E3779B9;

  logic clk = 0, rst = 1, start = 0, decrypt = 0, key_we = 0;
  logic [31:0] v0_in = 0, v1_in = 0, key_wdata = 0;
  logic [CNT_W-1:0] cycles = 0;
  logic [1:0] key_addr = 0;
  logic [31:0] key_rdata, v0_out, v1_out;
  logic busy, done;

  always #5 clk = ~clk;

  xtea_engine #(.CNT_W(CNT_W)) u_xtea_engine (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .v0_in(v0_in),
    .v1_in(v1_in), .cycles(cycles), .key_we(key_we), .key_addr(key_addr),
    .key_wdata(key_wdata), .key_rdata(key_rdata), .v0_out(v0_out),
    .v1_out(v1_out), .busy(busy), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mixf(input logic [31:0] x);
    return ((x << 4) ^ (x >> 5)) + x;
  endfunction

  // ---------------- behavioural cycle model ----------------
  logic [31:0] mk [4];
  logic [31:0] m_v0, m_v1, m_sum, m_rd;
  bit m_busy, m_done, m_dec;
  int m_left, m_ph;

  always @(posedge clk) begin
    if (rst) begin
      m_v0 = 0; m_v1 = 0; m_sum = 0; m_rd = 0;
      m_busy = 0; m_done = 0; m_dec = 0; m_left = 0; m_ph = 0;
      for (int i = 0; i < 4; i++) mk[i] = 0;
    end else begin
      m_rd = mk[key_addr];
      m_done = 0;
      if (m_busy) begin
        if (!m_dec) begin
          if (m_ph == 0) begin m_v0 = m_v0 + (mixf(m_v1) ^ (m_sum + mk[m_sum[1:0]])); m_sum = m_sum + DLT; end
          else m_v1 = m_v1 + (mixf(m_v0) ^ (m_sum + mk[m_sum[12:11]]));
        end else begin
          if (m_ph == 0) begin m_v1 = m_v1 - (mixf(m_v0) ^ (m_sum + mk[m_sum[12:11]])); m_sum = m_sum - DLT; end
          else m_v0 = m_v0 - (mixf(m_v1) ^ (m_sum + mk[m_sum[1:0]]));
        end
        m_ph = 1 - m_ph;
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        m_v0 = v0_in; m_v1 = v1_in; m_dec = decrypt; m_ph = 0;
        m_sum = decrypt ? DLT * 32'(cycles) : 32'h0;
        m_left = 2 * int'(cycles);
        if (cycles == 0) m_done = 1; else m_busy = 1;
      end
      if (key_we) mk[key_addr] = key_wdata;
    end
  end

  // ---------------- per-clock comparison ----------------
  logic [31:0] p_v0 = 0, p_v1 = 0;
  bit p_busy = 0;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(m_dec ? "R4 v0 per-clock" : "R3 v0 per-clock", v0_out, m_v0);
      chk(m_dec ? "R4 v1 per-clock" : "R3 v1 per-clock", v1_out, m_v1);
      chk("R5 busy per-clock", {31'b0, busy}, {31'b0, m_busy});
      chk("R5 done per-clock", {31'b0, done}, {31'b0, m_done});
      chk("R2 key_rdata per-clock", key_rdata, m_rd);
      if (p_busy)
        chk("R9 halves changed", 32'((v0_out !== p_v0) + (v1_out !== p_v1)) <= 1 ? 32'd1 : 32'd0, 32'd1);
    end
    p_v0 = v0_out; p_v1 = v1_out; p_busy = busy;
  end

  // ---------------- closed-form references ----------------
  function automatic void ref_enc(input int n, inout logic [31:0] a, inout logic [31:0] b);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i++) begin
      a += (mixf(b) ^ (s + mk[s[1:0]]));
      s += DLT;
      b += (mixf(a) ^ (s + mk[s[12:11]]));
    end
  endfunction

  function automatic void ref_dec(input int n, inout logic [31:0] a, inout logic [31:0] b);
    logic [31:0] s = DLT * 32'(n);
    for (int i = 0; i < n; i++) begin
      b -= (mixf(a) ^ (s + mk[s[12:11]]));
      s -= DLT;
      a -= (mixf(b) ^ (s + mk[s[1:0]]));
    end
  endfunction

  task automatic key_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); key_we = 1; key_addr = a; key_wdata = d;
    @(negedge clk); key_we = 0;
  endtask

  task automatic run_op(input bit dec, input logic [31:0] a, input logic [31:0] b,
                        input int n, output int lat);
    @(negedge clk); decrypt = dec; v0_in = a; v1_in = b; cycles = CNT_W'(n); start = 1;
    @(negedge clk); start = 0; lat = 1;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int lat;
    logic [31:0] ea, eb, pa, pb;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 v0 reset", v0_out, 0);
    chk("R1 v1 reset", v1_out, 0);
    chk("R1 busy reset", {31'b0, busy}, 0);
    chk("R1 done reset", {31'b0, done}, 0);
    chk("R1 key reset", key_rdata, 0);

    // R2 key write and read back
    key_write(0, 32'h207230BA);
    key_write(1, 32'h1FFBA710);
    key_write(2, 32'hC45271EF);
    key_write(3, 32'hDD01768A);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); key_addr = 2'(i);
      @(negedge clk); chk("R2 key readback", key_rdata, mk[i]);
    end

    // R3 encrypt 20 cycles, R5 latency
    pa = 32'h01234567; pb = 32'h89ABCDEF;
    run_op(0, pa, pb, 20, lat);
    ea = pa; eb = pb; ref_enc(20, ea, eb);
    chk("R3 enc v0", v0_out, ea);
    chk("R3 enc v1", v1_out, eb);
    chk("R5 latency", 32'(lat), 32'd41);
    @(negedge clk);
    chk("R5 done single pulse", {31'b0, done}, 0);

    // R4 decrypt returns plaintext
    run_op(1, ea, eb, 20, lat);
    chk("R4 dec v0", v0_out, pa);
    chk("R4 dec v1", v1_out, pb);

    // R7 hold while idle
    repeat (5) @(negedge clk);
    chk("R7 hold v0", v0_out, pa);
    chk("R7 hold v1", v1_out, pb);

    // R3 short counts and R4 on arbitrary data
    run_op(0, 32'hFFFFFFFF, 32'h00000000, 1, lat);
    ea = 32'hFFFFFFFF; eb = 0; ref_enc(1, ea, eb);
    chk("R3 enc n1 v0", v0_out, ea);
    chk("R3 enc n1 v1", v1_out, eb);
    chk("R5 latency n1", 32'(lat), 32'd3);
    run_op(1, 32'hDEADBEEF, 32'hCAFEF00D, 3, lat);
    ea = 32'hDEADBEEF; eb = 32'hCAFEF00D; ref_dec(3, ea, eb);
    chk("R4 dec n3 v0", v0_out, ea);
    chk("R4 dec n3 v1", v1_out, eb);

    // R6 start while busy ignored
    @(negedge clk); decrypt = 0; v0_in = 32'h11112222; v1_in = 32'h33334444; cycles = 8'd10; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    decrypt = 1; v0_in = 32'hAAAAAAAA; v1_in = 32'h55555555; cycles = 8'd2; start = 1;
    @(negedge clk); start = 0; lat = 5;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    ea = 32'h11112222; eb = 32'h33334444; ref_enc(10, ea, eb);
    chk("R6 result v0", v0_out, ea);
    chk("R6 result v1", v1_out, eb);
    chk("R6 latency", 32'(lat), 32'd21);

    // R8 zero count
    run_op(0, 32'hA5A5A5A5, 32'h5A5A5A5A, 0, lat);
    chk("R8 latency", 32'(lat), 32'd1);
    chk("R8 busy", {31'b0, busy}, 0);
    chk("R8 v0 passthrough", v0_out, 32'hA5A5A5A5);
    chk("R8 v1 passthrough", v1_out, 32'h5A5A5A5A);

    // new key, longer run to spread sum[12:11]
    key_write(2, 32'h0F1E2D3C);
    run_op(0, 32'h76543210, 32'hFEDCBA98, 32, lat);
    ea = 32'h76543210; eb = 32'hFEDCBA98; ref_enc(32, ea, eb);
    chk("R3 enc n32 v0", v0_out, ea);
    chk("R3 enc n32 v1", v1_out, eb);
    run_op(1, ea, eb, 32, lat);
    chk("R4 round trip v0", v0_out, 32'h76543210);
    chk("R4 round trip v1", v1_out, 32'hFEDCBA98);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule